// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that software controls only through 16-bit key values written to a command register, which cannot be read back. Three keys are recognised. One key opens the two configuration registers for writing. One key starts the watchdog. One key refreshes the count. The two configuration registers are a divider select and a 12-bit reload value. Writing any other value to the command register closes the configuration registers again. Once started, the watchdog cannot be stopped. A down-counter steps at the divided clock rate, and when it is exhausted the block raises a reset request that stays high until the system reset.

A write to a configuration register does not take effect at once. The new value is held in a staging register. The matching busy flag in the status register is set and stays set for a fixed number of clock cycles (5 by default). When the flag clears, the new value becomes the one the counter uses. While the flag is set, a read of that register returns zero.

Software must write the refresh key often enough to keep the reset request low. The watchdog clock is taken to be the same as the bus clock; the crossing from a slow oscillator is left to the surrounding logic. The write data is 16 bits wide because bits 31:16 of every register are reserved: a 16-bit and a 32-bit write have the same effect, and reads return zeros in the upper half.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, the reset request is low and the counter is idle. The divider select reads 0, the reload value reads 0xFFF and the status reads 0.
- R2: Register word indices are 0 for the command register, 1 for the divider select (bits 2:0), 2 for the reload value (bits 11:0) and 3 for the status register. Writes to index 1 or 2 take effect only after key 0x5555 has been written to index 0; before that they are ignored.
- R3: Writing any 16-bit value other than 0x5555 to index 0 closes the configuration registers again, so later writes to index 1 or 2 are ignored.
- R4: Reading index 0 always returns 0.
- R5: An accepted configuration write sets its status bit (bit 0 for the divider select, bit 1 for the reload value). The bit stays set for 5 cycles after the write edge, and a new write restarts that window. While the bit is set, the register reads 0. When the bit clears, the register reads the new value and the counter uses it.
- R6: Key 0xCCCC loads the counter from the reload value R currently in use and starts counting. With no further key writes, the reset request rises (R+1)*D cycles after the key write edge, where D is the current divide ratio.
- R7: Divider selects 0 to 7 give D = 4, 8, 16, 32, 64, 128, 256 and 256.
- R8: Key 0xAAAA reloads the counter and restarts the divider phase, so the reset request moves to (R+1)*D cycles after that write. If the refresh key lands on the very cycle in which the counter would expire, the refresh takes priority and no reset request is raised.
- R9: Once started, the counter cannot be stopped by any key value. Once the reset request is high, it stays high until the system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | 2 | Word index of the write |
| bus_wdata | input | 16 | Write data (bits 15:0; upper half reserved) |
| bus_raddr | input | 2 | Word index of the read |
| bus_rdata | output | 32 | Read data for bus_raddr, combinational |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
Two events can fall on the same clock edge: the refresh key write and the tick that would exhaust a zero counter. The bench starts the counter with a short reload value and places the refresh key write on exactly the edge where the final tick is due. It then judges two things: the reset request must stay low on that edge, and it must rise a full (R+1)*D cycles after the refresh. Two configuration writes falling inside one busy window are also provoked, to check that the window restarts and that the first value is never applied.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam logic [15:0] KEY_UNLOCK = 16'h5555;
  localparam logic [15:0] KEY_START  = 16'hCCCC;
  localparam logic [15:0] KEY_RELOAD = 16'hAAAA;

  localparam logic [1:0] IDX_CMD  = 2'd0;
  localparam logic [1:0] IDX_PSC  = 2'd1;
  localparam logic [1:0] IDX_RLD  = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam int SEL_W = 3;
  localparam int PC_W  = 8;

  // Last value of the divider phase counter for a given divider select.
  // Ratio is 4 << sel, capped at 256.
  function automatic logic [PC_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    logic [15:0] ratio;
    if (sel >= 3'd6) ratio = 16'd256;
    else             ratio = 16'd4 << sel;
    return PC_W'(ratio - 16'd1);
  endfunction

endpackage

// File: rtl/wdt_keyed_keys.sv
module wdt_keyed_keys
  import wdt_keyed_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr_i,
  input  logic [15:0] key_i,
  output logic        unlocked_o,
  output logic        start_o,
  output logic        reload_o
);

  logic unl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        unl_q <= 1'b0;
    else if (cmd_wr_i) unl_q <= (key_i == KEY_UNLOCK);
  end

  assign unlocked_o = unl_q;
  assign start_o    = cmd_wr_i && (key_i == KEY_START);
  assign reload_o   = cmd_wr_i && (key_i == KEY_RELOAD);

  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && key_i == KEY_UNLOCK) |=> unlocked_o);

  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && key_i != KEY_UNLOCK) |=> !unlocked_o);

  p_hold_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_i |=> $stable(unlocked_o));

endmodule

// File: rtl/wdt_keyed_shadow.sv
module wdt_keyed_shadow #(
  parameter int             W     = 3,
  parameter logic [W-1:0]   INIT  = '0,
  parameter int             PEND  = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] val_o,
  output logic         pend_o
);

  localparam int PW = $clog2(PEND + 1);

  logic [W-1:0]  stg_q;
  logic [W-1:0]  val_q;
  logic [PW-1:0] left_q;
  logic          apply_ev;

  assign apply_ev = !wr_i && (left_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= INIT;
      val_q  <= INIT;
      left_q <= '0;
    end else if (wr_i) begin
      stg_q  <= data_i;
      left_q <= PW'(PEND);
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
      if (apply_ev) val_q <= stg_q;
    end
  end

  assign val_o  = val_q;
  assign pend_o = (left_q != '0);

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(stg_q));

  p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_o);

  p_val_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pend_o) |-> $stable(val_o));

  p_val_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> (val_o == stg_q));

endmodule

// File: rtl/wdt_keyed_core.sv
module wdt_keyed_core
  import wdt_keyed_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic [PC_W-1:0]  last_i,
  output logic             req_o
);

  logic             run_q;
  logic             req_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  pc_q;
  logic             tick_ev;
  logic             expire_ev;

  assign tick_ev   = run_q && (pc_q >= last_i);
  assign expire_ev = tick_ev && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '0;
      pc_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= rld_i;
      pc_q  <= '0;
    end else if (reload_i) begin
      cnt_q <= rld_i;
      pc_q  <= '0;
    end else if (run_q) begin
      pc_q <= tick_ev ? '0 : pc_q + PC_W'(1);
      if (tick_ev && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      if (expire_ev) req_q <= 1'b1;
    end
  end

  assign req_o = req_q;

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> req_o);

  p_no_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  p_start_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == $past(rld_i)));

  p_reload_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !start_i && !req_o) |=> !req_o);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> !req_o);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !reload_i) |=>
      ((cnt_q == $past(cnt_q)) || (32'(cnt_q) + 1 == 32'($past(cnt_q)))));

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int           CNT_W    = 12,
  parameter int           PEND_CYC = 5,
  parameter logic [11:0]  RLD_INIT = 12'hFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_waddr,
  input  logic [15:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_req
);

  logic             cmd_wr, psc_wr, rld_wr;
  logic             unlocked, start_ev, reload_ev;
  logic [SEL_W-1:0] psc_val;
  logic [CNT_W-1:0] rld_val;
  logic             psc_pend, rld_pend;

  assign cmd_wr = bus_wr && (bus_waddr == IDX_CMD);
  assign psc_wr = bus_wr && (bus_waddr == IDX_PSC) && unlocked;
  assign rld_wr = bus_wr && (bus_waddr == IDX_RLD) && unlocked;

  wdt_keyed_keys i_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr_i   (cmd_wr),
    .key_i      (bus_wdata),
    .unlocked_o (unlocked),
    .start_o    (start_ev),
    .reload_o   (reload_ev)
  );

  wdt_keyed_shadow #(.W(SEL_W), .INIT('0), .PEND(PEND_CYC)) i_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (psc_wr),
    .data_i (bus_wdata[SEL_W-1:0]),
    .val_o  (psc_val),
    .pend_o (psc_pend)
  );

  wdt_keyed_shadow #(.W(CNT_W), .INIT(CNT_W'(RLD_INIT)), .PEND(PEND_CYC)) i_rld (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (rld_wr),
    .data_i (bus_wdata[CNT_W-1:0]),
    .val_o  (rld_val),
    .pend_o (rld_pend)
  );

  wdt_keyed_core #(.CNT_W(CNT_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_ev),
    .reload_i (reload_ev),
    .rld_i    (rld_val),
    .last_i   (div_last(psc_val)),
    .req_o    (wdt_rst_req)
  );

  always_comb begin
    unique case (bus_raddr)
      IDX_PSC:  bus_rdata = psc_pend ? 32'd0 : 32'(psc_val);
      IDX_RLD:  bus_rdata = rld_pend ? 32'd0 : 32'(rld_val);
      IDX_STAT: bus_rdata = {30'd0, rld_pend, psc_pend};
      default:  bus_rdata = 32'd0;
    endcase
  end

  p_cmd_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == IDX_CMD) |-> (bus_rdata == 32'd0));

  p_locked_psc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == IDX_PSC && !unlocked && !psc_pend) |=> !psc_pend);

endmodule

// File: tb/test_wdt_keyed_top.sv
`timescale 1ns/100ps
module test_wdt_keyed_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_waddr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [1:0]  bus_raddr = 2'd0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  wdt_keyed_top i_wdt_keyed_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req)
  );

  // Behavioural reference model
  int m_unl, m_run, m_cnt, m_pc, m_req;
  int m_ps_stg, m_ps_eff, m_ps_pend;
  int m_rl_stg, m_rl_eff, m_rl_pend;

  function automatic int ratio(int s);
    return (s >= 6) ? 256 : (2 ** (s + 2));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unl = 0; m_run = 0; m_cnt = 0; m_pc = 0; m_req = 0;
      m_ps_stg = 0; m_ps_eff = 0; m_ps_pend = 0;
      m_rl_stg = 4095; m_rl_eff = 4095; m_rl_pend = 0;
    end else begin
      int key;
      bit w_cmd, w_ps, w_rl, tick;
      key  = int'(bus_wdata);
      w_cmd = bus_wr && bus_waddr == 2'd0;
      w_ps  = bus_wr && bus_waddr == 2'd1 && m_unl != 0;
      w_rl  = bus_wr && bus_waddr == 2'd2 && m_unl != 0;
      tick  = (m_run != 0) && (m_pc + 1 >= ratio(m_ps_eff));
      if (w_cmd && key == 'hCCCC) begin
        m_run = 1; m_cnt = m_rl_eff; m_pc = 0;
      end else if (w_cmd && key == 'hAAAA) begin
        m_cnt = m_rl_eff; m_pc = 0;
      end else if (m_run != 0) begin
        if (tick) begin
          m_pc = 0;
          if (m_cnt == 0) m_req = 1; else m_cnt = m_cnt - 1;
        end else m_pc = m_pc + 1;
      end
      if (w_ps) begin m_ps_stg = int'(bus_wdata[2:0]); m_ps_pend = 5; end
      else if (m_ps_pend > 0) begin
        m_ps_pend--; if (m_ps_pend == 0) m_ps_eff = m_ps_stg;
      end
      if (w_rl) begin m_rl_stg = int'(bus_wdata[11:0]); m_rl_pend = 5; end
      else if (m_rl_pend > 0) begin
        m_rl_pend--; if (m_rl_pend == 0) m_rl_eff = m_rl_stg;
      end
      if (w_cmd) m_unl = (key == 'h5555) ? 1 : 0;
    end
  end

  function automatic int model_read(logic [1:0] idx);
    case (idx)
      2'd1: return (m_ps_pend > 0) ? 0 : m_ps_eff;
      2'd2: return (m_rl_pend > 0) ? 0 : m_rl_eff;
      2'd3: return ((m_rl_pend > 0) ? 2 : 0) + ((m_ps_pend > 0) ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic check(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", t, got, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " model req"}, int'(wdt_rst_req), m_req);
      check({tag, " model rdata"}, int'(bus_rdata), model_read(bus_raddr));
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] idx, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = idx; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string t, logic [1:0] idx, int exp);
    bus_raddr = idx; #0.5;
    check(t, int'(bus_rdata), exp);
  endtask

  task automatic measure(string t, int exp);
    int n = 0;
    while (!wdt_rst_req && n < 5000) begin @(posedge clk); #1; n++; end
    check(t, n, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    tag = "R1";
    rd_check("R1 psc", 2'd1, 0);
    rd_check("R1 rld", 2'd2, 'hFFF);
    rd_check("R1 stat", 2'd3, 0);
    check("R1 req", int'(wdt_rst_req), 0);
    repeat (20) @(posedge clk); #1;
    check("R1 idle req", int'(wdt_rst_req), 0);

    tag = "R2";
    wr(2'd1, 16'd5);
    rd_check("R2 locked stat", 2'd3, 0);
    repeat (6) @(posedge clk); #1;
    rd_check("R2 locked psc", 2'd1, 0);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd1);
    tag = "R5";
    rd_check("R5 psc busy flag", 2'd3, 1);
    rd_check("R5 psc busy read", 2'd1, 0);
    repeat (4) @(posedge clk); #1;
    rd_check("R5 psc still busy", 2'd3, 1);
    @(posedge clk); #1;
    rd_check("R5 psc flag clear", 2'd3, 0);
    rd_check("R5 psc applied", 2'd1, 1);

    tag = "R4";
    rd_check("R4 cmd read", 2'd0, 0);

    tag = "R3";
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'd5);
    repeat (6) @(posedge clk); #1;
    rd_check("R3 relocked rld", 2'd2, 'hFFF);

    tag = "R5";
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd3);
    rd_check("R5 rld busy flag", 2'd3, 2);
    repeat (5) @(posedge clk); #1;
    rd_check("R5 rld applied", 2'd2, 3);
    wr(2'd1, 16'd2);
    repeat (2) @(posedge clk); #1;
    wr(2'd1, 16'd1);
    repeat (4) @(posedge clk); #1;
    rd_check("R5 restart busy", 2'd3, 1);
    @(posedge clk); #1;
    rd_check("R5 restart clear", 2'd3, 0);
    rd_check("R5 restart value", 2'd1, 1);

    tag = "R6";
    wr(2'd0, 16'hCCCC);
    measure("R6 expiry cycles", 4 * 8);
    check("R6 req high", int'(wdt_rst_req), 1);

    tag = "R9";
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'hCCCC);
    repeat (10) @(posedge clk); #1;
    check("R9 sticky req", int'(wdt_rst_req), 1);

    do_reset();
    tag = "R9";
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd3);
    repeat (6) @(posedge clk); #1;
    wr(2'd0, 16'hCCCC);
    repeat (5) @(posedge clk); #1;
    wr(2'd0, 16'h0000);
    measure("R9 no stop", 16 - 6);

    do_reset();
    tag = "R8";
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd2);
    repeat (6) @(posedge clk); #1;
    wr(2'd0, 16'hCCCC);
    repeat (11) @(posedge clk); #1;
    check("R8 before race", int'(wdt_rst_req), 0);
    wr(2'd0, 16'hAAAA);
    check("R8 refresh wins", int'(wdt_rst_req), 0);
    measure("R8 after refresh", 12);

    tag = "R7";
    for (int s = 0; s < 8; s++) begin
      do_reset();
      wr(2'd0, 16'h5555);
      wr(2'd2, 16'd0);
      wr(2'd1, 16'(s));
      repeat (6) @(posedge clk); #1;
      wr(2'd0, 16'hCCCC);
      measure($sformatf("R7 ratio sel %0d", s), ratio(s));
    end

    finish_run();
  end

endmodule